// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block drives repeated raw AUX channel attempts on behalf of a caller. The caller posts one request (direction and requested length) with a start pulse. The controller launches attempts towards a raw transaction engine. After each attempt it looks at the channel result, the reply code and the returned data byte count. From these it decides whether to finish with success, finish with failure, or try again.

The outcome categories each have their own retry budget, and the budgets interact. AUX defers, I2C-over-AUX defers and I2C-over-AUX NACKs draw from one shared pool. An I2C defer empties that pool and counts against a budget of its own. Once a defer has been seen, a timeout is charged to the defer pool instead of the timeout budget. Any successful channel result refreshes the timeout and invalid-reply budgets. Retries that follow a defer are held back by a programmable number of clock cycles. A global attempt ceiling bounds the whole exchange.

Top module: `aux_retry_ctrl`

## Requirements
- R1: While and directly after reset, `req_done`, `req_pass` and `att_start` are low.
- R2: A request makes at most `MAX_ATTEMPTS` attempts (default 7). When a retry is called for after the last allowed attempt, the request ends with `req_done` high and `req_pass` low.
- R3: A channel result of 0 (ok) with reply 0 (ACK) ends in success. The exception is a read whose `att_bytes` differs from the requested length: that is retried, and the request fails once `ACK_LIMIT` (default 7) such short ACKs have been counted.
- R4: Reply 2 (AUX defer) and reply 5 (I2C-over-AUX defer) set a defer-seen flag. They share one budget of `DEFER_LIMIT` (default 7) with reply 3 (I2C-over-AUX NACK), and reaching it fails the request. A defer delays the next `att_start` by `cfg_defer_wait` cycles, so the next attempt starts `cfg_defer_wait`+1 cycles after the result cycle. A NACK retries after 1 cycle.
- R5: Reply 4 (I2C defer) clears the shared defer budget and counts against its own limit `I2C_DEFER_LIMIT` (default 7). It retries without a wait.
- R6: Reply 1 (AUX NACK), reply 6 (hot-plug disconnect) and the unassigned reply code 7, arriving with channel result 0, fail the request at once.
- R7: Channel result 1 (invalid reply) retries without a wait, and the request fails when `INVALID_LIMIT` (default 2) such results have been counted.
- R8: Channel result 2 (timeout) behaves in one of two ways. After a defer has been seen in the request, it counts against the defer budget and waits like a defer. Otherwise it counts against `TIMEOUT_LIMIT` (default 3) and retries after 1 cycle.
- R9: Every attempt with channel result 0 clears the timeout and invalid-reply counts.
- R10: Channel results 3 (hot-plug disconnect), 4 (engine acquire failure), 5 (unknown) and the unassigned codes 6 and 7 fail the request at once.
- R11: A new `req_start` clears every budget counter and the defer-seen flag.
- R12: A `cfg_defer_wait` of 0 removes the defer wait. `req_done` is a one-cycle pulse, and `req_pass` keeps its value until the next request starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse for a new request, taken when idle |
| req_is_write | input | 1 | Request is a write (1) or read (0) |
| req_len | input | LEN_W | Requested data length in bytes |
| cfg_defer_wait | input | WAIT_W | Cycles to wait before retrying after a defer |
| req_done | output | 1 | One-cycle pulse when the request finishes |
| req_pass | output | 1 | Outcome of the last finished request |
| att_start | output | 1 | One-cycle pulse launching a raw attempt |
| att_result_valid | input | 1 | Raw attempt result is present this cycle |
| att_result | input | 3 | Channel result code |
| att_reply | input | 3 | Reply code, meaningful for channel result 0 |
| att_bytes | input | LEN_W | Data bytes returned by the attempt |

## Verification
The hardest situation to reach from the ports is the interplay of the I2C-defer clear with the global ceiling. With the default budgets, the ceiling and the defer pool are both 7, so a clear of the defer pool can never change an outcome that the ports show. The bench therefore builds the controller with a small defer pool and a larger attempt ceiling. It then scripts runs of defers broken up by I2C defers, which carry a request past what an uncleared pool would allow and onto the ceiling itself. The defer wait and the charging of timeouts to the defer pool are observed as the cycle gap between each result and the next attempt start.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        CH_OK      = 3'd0,
        CH_INVALID = 3'd1,
        CH_TIMEOUT = 3'd2,
        CH_HPD     = 3'd3,
        CH_ACQUIRE = 3'd4,
        CH_UNKNOWN = 3'd5
    } chan_res_e;

    typedef enum logic [2:0] {
        RP_ACK       = 3'd0,
        RP_NACK      = 3'd1,
        RP_DEFER     = 3'd2,
        RP_OVR_NACK  = 3'd3,
        RP_I2C_DEFER = 3'd4,
        RP_OVR_DEFER = 3'd5,
        RP_HPD       = 3'd6
    } reply_e;

    typedef enum logic [1:0] {
        V_PASS,
        V_FAIL,
        V_RETRY,
        V_RETRY_WAIT
    } verdict_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_PAUSE
    } state_e;

    typedef struct packed {
        logic             seen;
        logic [CNT_W-1:0] ack;
        logic [CNT_W-1:0] defer;
        logic [CNT_W-1:0] i2c;
        logic [CNT_W-1:0] tmo;
        logic [CNT_W-1:0] inv;
    } budget_t;

    // True once a counter has reached its limit
    function automatic logic spent(input logic [CNT_W-1:0] cnt, input int lim);
        return int'(cnt) >= lim;
    endfunction

endpackage

// File: rtl/aux_retry_judge.sv
module aux_retry_judge
    import aux_retry_pkg::*;
#(
    parameter int LEN_W           = 5,
    parameter int ACK_LIMIT       = 7,
    parameter int DEFER_LIMIT     = 7,
    parameter int I2C_DEFER_LIMIT = 7,
    parameter int INVALID_LIMIT   = 2,
    parameter int TIMEOUT_LIMIT   = 3
) (
    input  budget_t          cur,
    input  logic [2:0]       result,
    input  logic [2:0]       reply,
    input  logic             is_write,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] bytes,
    output budget_t          nxt,
    output verdict_e         verdict
);

    chan_res_e res;
    reply_e    rep;

    assign res = chan_res_e'(result);
    assign rep = reply_e'(reply);

    always_comb begin
        nxt     = cur;
        verdict = V_FAIL;
        case (res)
            CH_OK: begin
                nxt.tmo = '0;
                nxt.inv = '0;
                case (rep)
                    RP_ACK: begin
                        if (!is_write && (bytes != len)) begin
                            nxt.ack = cur.ack + 1'b1;
                            verdict = spent(nxt.ack, ACK_LIMIT) ? V_FAIL : V_RETRY;
                        end else begin
                            verdict = V_PASS;
                        end
                    end
                    RP_DEFER, RP_OVR_DEFER: begin
                        nxt.seen  = 1'b1;
                        nxt.defer = cur.defer + 1'b1;
                        verdict   = spent(nxt.defer, DEFER_LIMIT) ? V_FAIL : V_RETRY_WAIT;
                    end
                    RP_OVR_NACK: begin
                        nxt.defer = cur.defer + 1'b1;
                        verdict   = spent(nxt.defer, DEFER_LIMIT) ? V_FAIL : V_RETRY;
                    end
                    RP_I2C_DEFER: begin
                        nxt.defer = '0;
                        nxt.i2c   = cur.i2c + 1'b1;
                        verdict   = spent(nxt.i2c, I2C_DEFER_LIMIT) ? V_FAIL : V_RETRY;
                    end
                    default: verdict = V_FAIL;
                endcase
            end
            CH_INVALID: begin
                nxt.inv = cur.inv + 1'b1;
                verdict = spent(nxt.inv, INVALID_LIMIT) ? V_FAIL : V_RETRY;
            end
            CH_TIMEOUT: begin
                if (cur.seen) begin
                    nxt.defer = cur.defer + 1'b1;
                    verdict   = spent(nxt.defer, DEFER_LIMIT) ? V_FAIL : V_RETRY_WAIT;
                end else begin
                    nxt.tmo = cur.tmo + 1'b1;
                    verdict = spent(nxt.tmo, TIMEOUT_LIMIT) ? V_FAIL : V_RETRY;
                end
            end
            default: verdict = V_FAIL;
        endcase
    end

endmodule

// File: rtl/aux_retry_timer.sv
module aux_retry_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              busy,
    output logic              last
);

    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign last = (cnt == WAIT_W'(1));

endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
    import aux_retry_pkg::*;
#(
    parameter int LEN_W           = 5,
    parameter int WAIT_W          = 8,
    parameter int MAX_ATTEMPTS    = 7,
    parameter int ACK_LIMIT       = 7,
    parameter int DEFER_LIMIT     = 7,
    parameter int I2C_DEFER_LIMIT = 7,
    parameter int INVALID_LIMIT   = 2,
    parameter int TIMEOUT_LIMIT   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_start,
    input  logic              req_is_write,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [WAIT_W-1:0] cfg_defer_wait,
    output logic              req_done,
    output logic              req_pass,
    output logic              att_start,
    input  logic              att_result_valid,
    input  logic [2:0]        att_result,
    input  logic [2:0]        att_reply,
    input  logic [LEN_W-1:0]  att_bytes
);

    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);

    state_e           state;
    budget_t          cnts;
    budget_t          cnts_nxt;
    verdict_e         verdict;
    logic [ATT_W-1:0] att_cnt;
    logic             wr_q;
    logic [LEN_W-1:0] len_q;
    logic             res_take;
    logic             cap_hit;
    logic             want_wait;
    logic             tmr_load;
    logic             tmr_busy;
    logic             tmr_last;

    aux_retry_judge #(
        .LEN_W          (LEN_W),
        .ACK_LIMIT      (ACK_LIMIT),
        .DEFER_LIMIT    (DEFER_LIMIT),
        .I2C_DEFER_LIMIT(I2C_DEFER_LIMIT),
        .INVALID_LIMIT  (INVALID_LIMIT),
        .TIMEOUT_LIMIT  (TIMEOUT_LIMIT)
    ) u_judge (
        .cur     (cnts),
        .result  (att_result),
        .reply   (att_reply),
        .is_write(wr_q),
        .len     (len_q),
        .bytes   (att_bytes),
        .nxt     (cnts_nxt),
        .verdict (verdict)
    );

    aux_retry_timer #(
        .WAIT_W(WAIT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(cfg_defer_wait),
        .busy    (tmr_busy),
        .last    (tmr_last)
    );

    assign res_take  = (state == S_WAIT) && att_result_valid;
    assign cap_hit   = (int'(att_cnt) >= MAX_ATTEMPTS);
    assign want_wait = (verdict == V_RETRY_WAIT) && (cfg_defer_wait != '0);
    assign tmr_load  = res_take && want_wait && !cap_hit;
    assign att_start = (state == S_ISSUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cnts     <= '0;
            att_cnt  <= '0;
            wr_q     <= 1'b0;
            len_q    <= '0;
            req_done <= 1'b0;
            req_pass <= 1'b0;
        end else begin
            req_done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_start) begin
                        state    <= S_ISSUE;
                        cnts     <= '0;
                        att_cnt  <= '0;
                        wr_q     <= req_is_write;
                        len_q    <= req_len;
                        req_pass <= 1'b0;
                    end
                end
                S_ISSUE: begin
                    att_cnt <= att_cnt + 1'b1;
                    state   <= S_WAIT;
                end
                S_WAIT: begin
                    if (att_result_valid) begin
                        cnts <= cnts_nxt;
                        case (verdict)
                            V_PASS: begin
                                req_done <= 1'b1;
                                req_pass <= 1'b1;
                                state    <= S_IDLE;
                            end
                            V_FAIL: begin
                                req_done <= 1'b1;
                                req_pass <= 1'b0;
                                state    <= S_IDLE;
                            end
                            default: begin
                                if (cap_hit) begin
                                    req_done <= 1'b1;
                                    req_pass <= 1'b0;
                                    state    <= S_IDLE;
                                end else if (want_wait) begin
                                    state <= S_PAUSE;
                                end else begin
                                    state <= S_ISSUE;
                                end
                            end
                        endcase
                    end
                end
                S_PAUSE: begin
                    if (tmr_last) begin
                        state <= S_ISSUE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!req_done && !req_pass && !att_start)); // R1

    AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(att_cnt) <= MAX_ATTEMPTS); // R2

    AST_FULL_ACK_PASS: assert property (@(posedge clk) disable iff (rst)
        (res_take && att_result == 3'd0 && att_reply == 3'd0 &&
         (wr_q || att_bytes == len_q)) |=> (req_done && req_pass)); // R3

    AST_PAUSE_TIMED: assert property (@(posedge clk) disable iff (rst)
        (state == S_PAUSE) |-> tmr_busy); // R4

    AST_NACK_FAILS: assert property (@(posedge clk) disable iff (rst)
        (res_take && att_result == 3'd0 && att_reply == 3'd1) |=> (req_done && !req_pass)); // R6

    AST_CHAN_FAILS: assert property (@(posedge clk) disable iff (rst)
        (res_take && att_result >= 3'd3) |=> (req_done && !req_pass)); // R10

    AST_NO_WAIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_take && verdict == V_RETRY_WAIT && cfg_defer_wait == '0 && !cap_hit)
        |=> att_start); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done); // R12

endmodule

// File: tb/aux_retry_ctrl_tb.sv
module aux_retry_ctrl_tb;

    localparam int LEN_W  = 5;
    localparam int WAIT_W = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_start = 1'b0;
    logic              req_is_write = 1'b0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [WAIT_W-1:0] cfg_defer_wait = '0;
    logic              req_done;
    logic              req_pass;
    logic              att_start;
    logic              att_result_valid = 1'b0;
    logic [2:0]        att_result = '0;
    logic [2:0]        att_reply = '0;
    logic [LEN_W-1:0]  att_bytes = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int ncyc     = 0;
    int s_res [16];
    int s_rep [16];
    int s_b   [16];
    int gaps  [16];
    int last_att;

    always #2 clk = ~clk;

    // Small defer pool, larger ceiling: makes pool clearing visible
    aux_retry_ctrl #(
        .LEN_W          (LEN_W),
        .WAIT_W         (WAIT_W),
        .MAX_ATTEMPTS   (9),
        .ACK_LIMIT      (3),
        .DEFER_LIMIT    (4),
        .I2C_DEFER_LIMIT(3),
        .INVALID_LIMIT  (2),
        .TIMEOUT_LIMIT  (3)
    ) u_dut (
        .clk             (clk),
        .rst             (rst),
        .req_start       (req_start),
        .req_is_write    (req_is_write),
        .req_len         (req_len),
        .cfg_defer_wait  (cfg_defer_wait),
        .req_done        (req_done),
        .req_pass        (req_pass),
        .att_start       (att_start),
        .att_result_valid(att_result_valid),
        .att_result      (att_result),
        .att_reply       (att_reply),
        .att_bytes       (att_bytes)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        ncyc++;
    endtask

    task automatic put(input int i, input int res, input int rep, input int b);
        s_res[i] = res;
        s_rep[i] = rep;
        s_b[i]   = b;
    endtask

    task automatic run_req(input bit wr, input int len, input int w,
                           input int exp_att, input bit exp_pass, input string req);
        int  att   = 0;
        int  polls = 0;
        int  vcyc;
        bit  fin   = 0;
        bit  pass_seen;
        req_is_write   = wr;
        req_len        = LEN_W'(len);
        cfg_defer_wait = WAIT_W'(w);
        tick();
        req_start = 1'b1;
        tick();
        req_start = 1'b0;
        vcyc = ncyc;
        while (!fin && polls < 3000) begin
            if (req_done) begin
                fin = 1;
            end else if (att_start && att < 16) begin
                gaps[att] = ncyc - vcyc;
                att_result = 3'(s_res[att]);
                att_reply  = 3'(s_rep[att]);
                att_bytes  = LEN_W'(s_b[att]);
                att++;
                tick();
                att_result_valid = 1'b1;
                vcyc = ncyc;
                tick();
                att_result_valid = 1'b0;
            end else begin
                tick();
            end
            polls++;
        end
        last_att = att;
        check(fin, req, "request finished", int'(fin), 1);
        check(att == exp_att, req, "attempts", att, exp_att);
        check(req_pass == exp_pass, req, "pass", int'(req_pass), int'(exp_pass));
        pass_seen = req_pass;
        tick();
        check(!req_done && req_pass == pass_seen, "R12", "done pulse / pass hold",
              int'(req_done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: outputs quiet in reset
        check(!req_done && !req_pass && !att_start, "R1", "reset outputs",
              int'({req_done, req_pass, att_start}), 0);
        rst = 1'b0;
        tick();
        check(!req_done && !att_start, "R1", "idle after reset",
              int'({req_done, att_start}), 0);

        // R3: writes and full reads pass in one attempt over all lengths
        for (int l = 0; l < 8; l++) begin
            put(0, 0, 0, 0);
            run_req(1'b1, l, 0, 1, 1'b1, "R3");
            put(0, 0, 0, l);
            run_req(1'b0, l, 0, 1, 1'b1, "R3");
            put(0, 0, 0, l + 1); put(1, 0, 0, l);
            run_req(1'b0, l, 0, 2, 1'b1, "R3");
        end
        put(0, 0, 0, 1); put(1, 0, 0, 1); put(2, 0, 0, 1);
        run_req(1'b0, 4, 0, 3, 1'b0, "R3");

        // R4 / R12: defer wait sweep, gap = wait + 1
        for (int w = 0; w < 8; w++) begin
            put(0, 0, 2, 0); put(1, 0, 0, 0);
            run_req(1'b1, 0, w, 2, 1'b1, "R4");
            check(gaps[1] == w + 1, "R4", "defer gap", gaps[1], w + 1);
        end
        put(0, 0, 5, 0); put(1, 0, 0, 0);
        run_req(1'b1, 0, 5, 2, 1'b1, "R4");
        check(gaps[1] == 6, "R4", "over-aux defer gap", gaps[1], 6);
        put(0, 0, 3, 0); put(1, 0, 0, 0);
        run_req(1'b1, 0, 5, 2, 1'b1, "R4");
        check(gaps[1] == 1, "R4", "nack gap", gaps[1], 1);
        put(0, 0, 2, 0); put(1, 0, 3, 0); put(2, 0, 5, 0); put(3, 0, 2, 0);
        run_req(1'b1, 0, 0, 4, 1'b0, "R4");

        // R5 / R2: I2C defer empties the pool, run reaches the ceiling
        for (int i = 0; i < 3; i++) put(i, 0, 2, 0);
        put(3, 0, 4, 0);
        for (int i = 4; i < 7; i++) put(i, 0, 2, 0);
        put(7, 0, 4, 0); put(8, 0, 2, 0); put(9, 0, 0, 0);
        run_req(1'b1, 0, 0, 9, 1'b0, "R2");
        put(0, 0, 4, 0); put(1, 0, 4, 0); put(2, 0, 4, 0);
        run_req(1'b1, 0, 0, 3, 1'b0, "R5");

        // R6: fatal reply codes
        put(0, 0, 1, 0); run_req(1'b1, 0, 0, 1, 1'b0, "R6");
        put(0, 0, 6, 0); run_req(1'b1, 0, 0, 1, 1'b0, "R6");
        put(0, 0, 7, 0); run_req(1'b1, 0, 0, 1, 1'b0, "R6");
        put(0, 0, 2, 0); put(1, 0, 1, 0);
        run_req(1'b1, 0, 0, 2, 1'b0, "R6");

        // R7: invalid replies
        put(0, 1, 0, 0); put(1, 1, 0, 0);
        run_req(1'b1, 0, 0, 2, 1'b0, "R7");
        put(0, 1, 0, 0); put(1, 0, 0, 0);
        run_req(1'b1, 0, 3, 2, 1'b1, "R7");
        check(gaps[1] == 1, "R7", "invalid gap", gaps[1], 1);

        // R8: timeouts with and without a prior defer
        put(0, 2, 0, 0); put(1, 2, 0, 0); put(2, 2, 0, 0);
        run_req(1'b1, 0, 4, 3, 1'b0, "R8");
        check(gaps[1] == 1 && gaps[2] == 1, "R8", "plain timeout gap", gaps[2], 1);
        put(0, 0, 2, 0); put(1, 2, 0, 0); put(2, 2, 0, 0); put(3, 0, 0, 0);
        run_req(1'b1, 0, 4, 4, 1'b1, "R8");
        check(gaps[2] == 5, "R8", "timeout after defer gap", gaps[2], 5);
        check(gaps[3] == 5, "R8", "timeout after defer gap", gaps[3], 5);
        put(0, 0, 2, 0); put(1, 2, 0, 0); put(2, 2, 0, 0); put(3, 2, 0, 0);
        run_req(1'b1, 0, 0, 4, 1'b0, "R8");

        // R9: ok channel result refreshes invalid and timeout counts
        put(0, 1, 0, 0); put(1, 0, 2, 0); put(2, 1, 0, 0); put(3, 0, 0, 0);
        run_req(1'b1, 0, 0, 4, 1'b1, "R9");
        put(0, 2, 0, 0); put(1, 2, 0, 0); put(2, 0, 3, 0);
        put(3, 2, 0, 0); put(4, 2, 0, 0); put(5, 0, 0, 0);
        run_req(1'b1, 0, 0, 6, 1'b1, "R9");

        // R10: fatal channel results
        for (int c = 3; c < 8; c++) begin
            put(0, c, 0, 0);
            run_req(1'b1, 0, 0, 1, 1'b0, "R10");
        end

        // R11: budgets and defer-seen flag restart per request
        put(0, 0, 2, 0); put(1, 0, 2, 0); put(2, 0, 2, 0); put(3, 0, 0, 0);
        run_req(1'b1, 0, 0, 4, 1'b1, "R11");
        put(0, 0, 2, 0); put(1, 0, 0, 0);
        run_req(1'b1, 0, 0, 2, 1'b1, "R11");
        put(0, 2, 0, 0); put(1, 0, 0, 0);
        run_req(1'b1, 0, 3, 2, 1'b1, "R11");
        check(gaps[1] == 1, "R11", "seen flag cleared gap", gaps[1], 1);

        // R12: idle block ignores results without a request
        att_result_valid = 1'b1;
        att_result = 3'd0;
        att_reply  = 3'd0;
        tick();
        att_result_valid = 1'b0;
        tick();
        check(!req_done && !att_start, "R12", "idle ignores result",
              int'({req_done, att_start}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule